// File: doc/BRIEF.md
# Path Error Counters with Overstep Interrupts

This block totals path-layer error reports, one frame at a time, in three saturating 16-bit counters. When a frame is marked, it takes the eight-bit parity-difference mask of that frame's path parity byte, which is the XOR of the computed and the received byte. It also takes the path status byte that carries the far end's error report. From these it updates a bit-error total, an errored-frame total and a remote-error total.

A processor port reads and clears the counters and sets a threshold for each counter. Through the same port it enables the interrupt of each counter and clears the sticky overstep flags. The flags are ORed, through their enables, onto a single interrupt line. A frame's errors are never lost. This holds when a read clears a counter, and when a flag is cleared in the same cycle that a frame would set it again.

Top module: `path_err_cnt`

## Requirements
- R1: After reset all three counters read 0, the overstep flags and the enables are 0, every threshold is FFFFh, and `irq` is low.
- R2: In a cycle where `frm_vld` is high, the bit-error counter (address 0) grows by the number of set bits in `b3_err_mask`.
- R3: In a cycle where `frm_vld` is high, the errored-frame counter (address 1) grows by exactly one when `b3_err_mask` is non-zero, however many of its bits are set.
- R4: In a cycle where `frm_vld` is high, the remote-error counter (address 2) grows by the value in `g1_byte[7:4]` when that value is 0 to 7, and by zero when it is 8 or more.
- R5: Each counter holds at FFFFh and does not wrap.
- R6: A read (`cpu_rd`) at address 0, 1 or 2 returns the counter on `cpu_rdata` in the same cycle and clears it. If a frame arrives in that cycle, the counter holds that frame's increment afterwards.
- R7: A write at address 0, 1 or 2 loads the counter's threshold. Overstep flag i is set after any frame whose updated count i is strictly greater than threshold i, and it then stays set.
- R8: A write at address 3 clears each overstep flag i whose `cpu_wdata[8+i]` is 1. A flag that a frame sets in the same cycle stays set.
- R9: A write at address 3 loads the enables from `cpu_wdata[2:0]`. A read at address 3 returns the flags in bits 10:8 and the enables in bits 2:0, with every other bit 0. `irq` is high exactly when some flag and its enable are both 1.
- R10: While `frm_vld` is low, `b3_err_mask` and `g1_byte` leave every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | One-cycle strobe per frame; qualifies the two inputs below |
| b3_err_mask | input | 8 | Parity difference mask of the frame's path parity byte |
| g1_byte | input | 8 | Received path status byte; the remote-error value is in bits 7:4 |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 2 | 0..2 counter or threshold, 3 flags and enables |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid in the cycle of `cpu_rd` |
| irq | output | 1 | OR of the enabled overstep flags |

## Verification
Two kinds of event can land in one cycle. A frame can arrive in the cycle a read clears the counter it updates. A frame can also cross a threshold in the cycle the processor writes to clear that flag. The bench drives a frame and the read in one cycle, then reads the counter again; it expects the old total from the first read and only the new frame's increment from the second. It also drives an overstep frame together with a clearing write, and expects the flag and `irq` to remain set.

// File: rtl/path_err_cnt.sv
module path_err_cnt #(
  parameter int CW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_vld,
  input  logic [MW-1:0] b3_err_mask,
  input  logic [7:0]    g1_byte,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  output logic          irq
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [2:0][CW-1:0] cnt, thr, inc, nxt;
  logic [2:0]         sts, ien, hit, clr;
  logic [CW-1:0]      pc;

  always_comb begin
    pc = '0;
    for (int k = 0; k < MW; k++) pc = pc + CW'(b3_err_mask[k]);
    inc[0] = frm_vld ? pc : '0;
    inc[1] = CW'(frm_vld && (b3_err_mask != '0));
    inc[2] = (frm_vld && !g1_byte[7]) ? CW'(g1_byte[6:4]) : '0;
  end

  for (genvar i = 0; i < 3; i++) begin : g_cnt
    logic          rdhit;
    logic [CW:0]   sum;
    assign rdhit  = cpu_rd && (cpu_addr == 2'(i));
    assign sum    = {1'b0, rdhit ? {CW{1'b0}} : cnt[i]} + {1'b0, inc[i]};
    assign nxt[i] = sum[CW] ? MAXV : sum[CW-1:0];
    assign hit[i] = frm_vld && (nxt[i] > thr[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i] <= '0;
        thr[i] <= MAXV;
      end else begin
        cnt[i] <= nxt[i];
        if (cpu_wr && cpu_addr == 2'(i)) thr[i] <= cpu_wdata[CW-1:0];
      end
    end
  end

  assign clr = (cpu_wr && cpu_addr == 2'd3) ? cpu_wdata[10:8] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      ien <= '0;
    end else begin
      sts <= (sts & ~clr) | hit;
      if (cpu_wr && cpu_addr == 2'd3) ien <= cpu_wdata[2:0];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      case (cpu_addr)
        2'd0:    cpu_rdata = 16'(cnt[0]);
        2'd1:    cpu_rdata = 16'(cnt[1]);
        2'd2:    cpu_rdata = 16'(cnt[2]);
        default: cpu_rdata = {5'b0, sts, 5'b0, ien};
      endcase
    end
  end

  assign irq = |(sts & ien);
endmodule

module path_err_cnt_chk #(
  parameter int CW = 16,
  parameter int MW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frm_vld,
  input logic [MW-1:0]      b3_err_mask,
  input logic [7:0]         g1_byte,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic [1:0]         cpu_addr,
  input logic [15:0]        cpu_wdata,
  input logic               irq,
  input logic [2:0][CW-1:0] cnt,
  input logic [2:0][CW-1:0] thr,
  input logic [2:0]         sts,
  input logic [2:0]         ien
);
  localparam logic [CW-1:0] MAXV = '1;

  assert_block_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && !(cpu_rd && cpu_addr == 2'd1) && cnt[1] != MAXV
    |=> (cnt[1] - $past(cnt[1])) <= CW'(1));

  assert_rei_high_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && g1_byte[7] && !(cpu_rd && cpu_addr == 2'd2) |=> $stable(cnt[2]));

  assert_bit_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] == MAXV && !(cpu_rd && cpu_addr == 2'd0) |=> cnt[0] == MAXV);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == 2'd0 && !frm_vld |=> cnt[0] == '0);

  assert_flag_over_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) && $stable(thr[1]) |-> cnt[1] > thr[1]);

  for (genvar i = 0; i < 3; i++) begin : g_sticky
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sts[i] && !(cpu_wr && cpu_addr == 2'd3 && cpu_wdata[8+i]) |=> sts[i]);
  end

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 3'b000 |-> !irq);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld && !cpu_rd |=> $stable(cnt));
endmodule

bind path_err_cnt path_err_cnt_chk #(.CW(CW), .MW(MW)) u_chk (.*);

// File: tb/path_err_cnt_test.sv
`timescale 1ns/100ps
module path_err_cnt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_vld = 1'b0;
  logic [7:0]  b3_err_mask = '0;
  logic [7:0]  g1_byte = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        irq;

  always #2 clk = ~clk;

  path_err_cnt uut (.*);

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_cnt [3];
  logic [15:0] m_thr [3];
  logic [2:0]  m_sts = '0;
  logic [2:0]  m_ien = '0;

  task automatic cyc(input logic f, input logic [7:0] m, input logic [7:0] g,
                     input logic rd, input logic wr, input logic [1:0] a,
                     input logic [15:0] wd, input string tag);
    item_t it;
    int inc [3];
    int s;
    logic [2:0] set;
    logic [2:0] clr;
    frm_vld = f; b3_err_mask = m; g1_byte = g;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    if (rd) begin
      it.exp = (a == 2'd3) ? {5'b0, m_sts, 5'b0, m_ien} : m_cnt[a];
      it.tag = tag;
      q.push_back(it);
    end
    inc[0] = f ? $countones(m) : 0;
    inc[1] = (f && m != 8'h00) ? 1 : 0;
    inc[2] = (f && g[7:4] < 4'd8) ? int'(g[7:4]) : 0;
    set = '0;
    for (int i = 0; i < 3; i++) begin
      s = ((rd && a == 2'(i)) ? 0 : int'(m_cnt[i])) + inc[i];
      if (s > 65535) s = 65535;
      set[i] = f && (s > int'(m_thr[i]));
      m_cnt[i] = 16'(s);
    end
    clr = (wr && a == 2'd3) ? wd[10:8] : 3'b000;
    m_sts = (m_sts & ~clr) | set;
    if (wr && a == 2'd3) m_ien = wd[2:0];
    if (wr && a != 2'd3) m_thr[a] = wd;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] m, input logic [7:0] g, input string tag);
    cyc(1'b1, m, g, 1'b0, 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, a, 16'h0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    frm_vld = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    #0.5;
    e = |(m_sts & m_ien);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, e);
    end
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    #0.5;
    if (cpu_rd) begin
      item_t it;
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read with no expected item, rdata=%h expected none", cpu_rdata);
      end else begin
        it = q.pop_front();
        if (cpu_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, cpu_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run active=1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_cnt[i] = '0; m_thr[i] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, "R1 bit count at reset");
    rd(2'd1, "R1 block count at reset");
    rd(2'd2, "R1 rei count at reset");
    rd(2'd3, "R1 flags and enables at reset");
    chk_irq("R1 irq at reset");

    frame(8'hFF, 8'h00, "R2");
    frame(8'h01, 8'h00, "R2");
    frame(8'hA5, 8'h00, "R2");
    frame(8'h00, 8'h00, "R2");
    rd(2'd0, "R2 popcount total");
    rd(2'd1, "R3 one per errored frame");
    rd(2'd2, "R4 zero rei so far");

    frame(8'h00, 8'h70, "R4");
    frame(8'h00, 8'h35, "R4");
    frame(8'h00, 8'h80, "R4");
    frame(8'h00, 8'hF0, "R4");
    frame(8'h00, 8'h0F, "R4");
    rd(2'd2, "R4 rei total with 8 and above ignored");

    cyc(1'b0, 8'hFF, 8'h70, 1'b0, 1'b0, 2'd0, 16'h0, "R10");
    rd(2'd0, "R10 bit count without strobe");
    rd(2'd1, "R10 block count without strobe");
    rd(2'd2, "R10 rei count without strobe");

    frame(8'hFF, 8'h10, "R6");
    frame(8'hFF, 8'h10, "R6");
    cyc(1'b1, 8'h0F, 8'h50, 1'b1, 1'b0, 2'd0, 16'h0, "R6 read with frame, bit");
    rd(2'd0, "R6 increment kept after read, bit");
    cyc(1'b1, 8'h03, 8'h20, 1'b1, 1'b0, 2'd2, 16'h0, "R6 read with frame, rei");
    rd(2'd2, "R6 increment kept after read, rei");
    rd(2'd1, "R6 block clear");

    wr(2'd1, 16'd2, "R7");
    wr(2'd3, 16'h0002, "R9");
    frame(8'h01, 8'h00, "R7");
    frame(8'h10, 8'h00, "R7");
    chk_irq("R7 count equal to threshold, no flag");
    frame(8'h80, 8'h00, "R7");
    chk_irq("R7 overstep raises irq");
    rd(2'd3, "R7 flag visible");

    wr(2'd3, 16'h0202, "R8");
    chk_irq("R8 clear drops irq");
    cyc(1'b1, 8'h01, 8'h00, 1'b0, 1'b1, 2'd3, 16'h0202, "R8");
    chk_irq("R8 set wins over clear");
    rd(2'd3, "R8 flag after same-cycle clear");

    wr(2'd3, 16'h0000, "R9");
    chk_irq("R9 disabled irq");
    rd(2'd3, "R9 flag kept while disabled");
    wr(2'd3, 16'h0002, "R9");
    chk_irq("R9 re-enabled irq");

    rd(2'd0, "R5 clear before fill");
    for (int n = 0; n < 8200; n++) frame(8'hFF, 8'h00, "R5");
    rd(2'd0, "R5 saturated bit count");
    rd(2'd0, "R5 cleared after saturated read");
    rd(2'd1, "R5 block count after fill");

    chk_irq("final irq");
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: pending=%0d expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule